// File: doc/BRIEF.md
# SDI Serial Scrambler and Descrambler

This block carries 10-bit video words over a one-bit serial line and restores the bits on the far side. On transmit, a fixed-cadence serializer takes one word every ten clocks and shifts it out least significant bit first. The bit stream then passes through a self-synchronizing scrambler with generator x^9 + x^4 + 1, followed by a second x + 1 stage that turns each scrambled one into a line transition. The line therefore runs at ten times the word rate, with one serial bit per clock.

On receive, the serial input is descrambled by the inverse stages in reverse order. Adjacent received bits are XORed to undo the x + 1 stage. The result is XORed with its own values from four and nine bits earlier. The receiver keeps no state beyond the last ten received bits, so it locks to any transmitter without a seed. Any disturbance on the line (a flipped bit or a lost bit) spoils only a short window of output. An 8-bit mode clears the two low bits of every word before it is sent. Word alignment on the receive side is left to a later stage.

Top module: `sdi_serial_link`

## Requirements
- R1: While reset is high, and in the first cycle after reset, `tx_bit`, `tx_bit_valid`, `rx_bit` and `rx_bit_valid` are 0. `load_strobe` is 1 during reset, so the first word is sampled at the first clock edge after reset is released.
- R2: `load_strobe` is high for exactly one cycle in every ten. `word_in`, `word_valid` and `narrow_mode` are sampled at each rising edge where `load_strobe` is high.
- R3: A sampled word is sent least significant bit first. Its ten bits occupy ten consecutive serial positions, and no position is left between one word and the next.
- R4: When `narrow_mode` is 1 at the sampling edge, bits 1 and 0 of the word are sent as 0, and bits 9 to 2 are sent unchanged.
- R5: When `word_valid` is 0 at the sampling edge, a word of ten zero bits is sent in that slot.
- R6: Let b[n] be serial bit n, counted from 0 after reset. The bench forms s[n] = b[n] ^ s[n-4] ^ s[n-9] and t[n] = s[n] ^ t[n-1], with all earlier values taken as 0 after reset. Bit 0 of the first word appears on `tx_bit`, with `tx_bit_valid` high, after the second rising edge following reset release, and `tx_bit` = t[n]. From then on, `tx_bit_valid` stays 1 and one bit is sent per clock.
- R7: When `rx_in_valid` is 1 at a rising edge, `rx_bit_valid` is 1 after that edge. If `tx_bit` is looped to `rx_in` with no disturbance since reset, `rx_bit` equals the serial bit b[n] that was on the line at that edge.
- R8: After any disturbance of the received stream (inverted bits or skipped bits), once ten valid, contiguous, undisturbed bits have been accepted, every further output bit equals the transmitted bit, whatever the receiver held before.
- R9: When `rx_in_valid` is 0 at a rising edge, `rx_bit_valid` is 0 after that edge and `rx_bit` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| word_in | input | 10 | Parallel word to transmit |
| word_valid | input | 1 | Word present in this slot; otherwise zeros are sent |
| narrow_mode | input | 1 | 8-bit mode: clears bits 1 and 0 of the word |
| load_strobe | output | 1 | High in the cycle whose rising edge samples the word inputs |
| tx_bit | output | 1 | Scrambled serial line bit |
| tx_bit_valid | output | 1 | Line bit is meaningful |
| rx_in | input | 1 | Received serial line bit |
| rx_in_valid | input | 1 | Received bit is present this cycle |
| rx_bit | output | 1 | Descrambled bit |
| rx_bit_valid | output | 1 | Descrambled bit updated this cycle |

## Verification
If a scrambler history register holds a wrong value, the error shows on `tx_bit` within nine bits. It keeps recurring there, because the feedback feeds it back into the stream. A wrong descrambler tap or XOR stage shows on `rx_bit` in the same cycle it is used. A wrong starting state, by contrast, must clear by itself within ten accepted bits. The bench therefore tests two things: that the output is wrong only inside that window after a flipped or skipped bit, and exact agreement everywhere else. A serializer fault, whether bit order, slot length or masking, shows on both outputs within one word.

// File: rtl/sdi_link_pkg.sv
package sdi_link_pkg;

    localparam int SDI_WORD_W      = 10;
    localparam int NARROW_LOW_BITS = 2;
    localparam int SCR_NEAR_TAP    = 4;
    localparam int SCR_FAR_TAP     = 9;

    // One bit travelling between stages, with its qualifier.
    typedef struct packed {
        logic data;
        logic valid;
    } bit_beat_t;

    // Three-input tap sum shared by both directions.
    function automatic logic tap_sum(input logic a, input logic b, input logic c);
        return a ^ b ^ c;
    endfunction

endpackage

// File: rtl/sdi_word_serializer.sv
module sdi_word_serializer
    import sdi_link_pkg::*;
#(
    parameter int WORD_W   = SDI_WORD_W,
    parameter int LOW_ZERO = NARROW_LOW_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word_in,
    input  logic              word_valid,
    input  logic              narrow_mode,
    output logic              load_strobe,
    output bit_beat_t         ser_out
);

    localparam int                PH_W    = $clog2(WORD_W);
    localparam logic [PH_W-1:0]   PH_LAST = PH_W'(WORD_W - 1);

    logic [WORD_W-1:0] shreg_q;
    logic [PH_W-1:0]   phase_q;
    logic              primed_q;
    logic [WORD_W-1:0] masked;

    always_comb begin
        masked = word_in;
        if (narrow_mode) begin
            masked[LOW_ZERO-1:0] = '0;
        end
        if (!word_valid) begin
            masked = '0;
        end
    end

    assign load_strobe = (phase_q == PH_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q  <= '0;
            phase_q  <= PH_LAST;
            primed_q <= 1'b0;
        end else if (load_strobe) begin
            shreg_q  <= masked;
            phase_q  <= '0;
            primed_q <= 1'b1;
        end else begin
            shreg_q  <= {1'b0, shreg_q[WORD_W-1:1]};
            phase_q  <= phase_q + 1'b1;
        end
    end

    assign ser_out.data  = shreg_q[0];
    assign ser_out.valid = primed_q;

endmodule

// File: rtl/sdi_tx_scrambler.sv
module sdi_tx_scrambler
    import sdi_link_pkg::*;
#(
    parameter int NEAR_TAP = SCR_NEAR_TAP,
    parameter int FAR_TAP  = SCR_FAR_TAP
) (
    input  logic      clk,
    input  logic      rst,
    input  bit_beat_t din,
    output bit_beat_t dout
);

    logic [FAR_TAP-1:0] hist_q;
    logic               line_q;
    logic               valid_q;
    logic               stage1;

    // First stage: feedback from its own outputs at the two tap delays.
    assign stage1 = tap_sum(din.data, hist_q[NEAR_TAP-1], hist_q[FAR_TAP-1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q  <= '0;
            line_q  <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= din.valid;
            if (din.valid) begin
                hist_q <= {hist_q[FAR_TAP-2:0], stage1};
                // Second stage: a one toggles the line.
                line_q <= line_q ^ stage1;
            end
        end
    end

    assign dout.data  = line_q;
    assign dout.valid = valid_q;

endmodule

// File: rtl/sdi_rx_descrambler.sv
module sdi_rx_descrambler
    import sdi_link_pkg::*;
#(
    parameter int NEAR_TAP = SCR_NEAR_TAP,
    parameter int FAR_TAP  = SCR_FAR_TAP
) (
    input  logic      clk,
    input  logic      rst,
    input  bit_beat_t din,
    output bit_beat_t dout
);

    logic               prev_q;
    logic [FAR_TAP-1:0] hist_q;
    logic               out_q;
    logic               valid_q;
    logic               diff;
    logic               recovered;

    // Undo the transition stage first, then the feedback stage.
    assign diff      = din.data ^ prev_q;
    assign recovered = tap_sum(diff, hist_q[NEAR_TAP-1], hist_q[FAR_TAP-1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b0;
            hist_q  <= '0;
            out_q   <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= din.valid;
            if (din.valid) begin
                prev_q <= din.data;
                hist_q <= {hist_q[FAR_TAP-2:0], diff};
                out_q  <= recovered;
            end
        end
    end

    assign dout.data  = out_q;
    assign dout.valid = valid_q;

endmodule

// File: rtl/sdi_serial_link.sv
module sdi_serial_link
    import sdi_link_pkg::*;
#(
    parameter int WORD_W   = SDI_WORD_W,
    parameter int LOW_ZERO = NARROW_LOW_BITS,
    parameter int NEAR_TAP = SCR_NEAR_TAP,
    parameter int FAR_TAP  = SCR_FAR_TAP
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word_in,
    input  logic              word_valid,
    input  logic              narrow_mode,
    output logic              load_strobe,
    output logic              tx_bit,
    output logic              tx_bit_valid,
    input  logic              rx_in,
    input  logic              rx_in_valid,
    output logic              rx_bit,
    output logic              rx_bit_valid
);

    bit_beat_t ser_beat;
    bit_beat_t line_beat;
    bit_beat_t rx_beat;
    bit_beat_t rec_beat;
    logic      ser_bit_w;

    sdi_word_serializer #(
        .WORD_W   (WORD_W),
        .LOW_ZERO (LOW_ZERO)
    ) u_ser (
        .clk         (clk),
        .rst         (rst),
        .word_in     (word_in),
        .word_valid  (word_valid),
        .narrow_mode (narrow_mode),
        .load_strobe (load_strobe),
        .ser_out     (ser_beat)
    );

    sdi_tx_scrambler #(
        .NEAR_TAP (NEAR_TAP),
        .FAR_TAP  (FAR_TAP)
    ) u_scr (
        .clk  (clk),
        .rst  (rst),
        .din  (ser_beat),
        .dout (line_beat)
    );

    assign rx_beat.data  = rx_in;
    assign rx_beat.valid = rx_in_valid;

    sdi_rx_descrambler #(
        .NEAR_TAP (NEAR_TAP),
        .FAR_TAP  (FAR_TAP)
    ) u_dscr (
        .clk  (clk),
        .rst  (rst),
        .din  (rx_beat),
        .dout (rec_beat)
    );

    assign ser_bit_w    = ser_beat.data;
    assign tx_bit       = line_beat.data;
    assign tx_bit_valid = line_beat.valid;
    assign rx_bit       = rec_beat.data;
    assign rx_bit_valid = rec_beat.valid;

endmodule

// File: rtl/sdi_serial_link_chk.sv
module sdi_serial_link_chk #(
    parameter int WORD_W = 10
) (
    input logic clk,
    input logic rst,
    input logic word_lsb,
    input logic word_valid,
    input logic narrow_mode,
    input logic load_strobe,
    input logic ser_bit,
    input logic tx_bit,
    input logic tx_bit_valid,
    input logic rx_in_valid,
    input logic rx_bit,
    input logic rx_bit_valid
);

    localparam int              CW   = $clog2(WORD_W);
    localparam logic [CW-1:0]   LAST = CW'(WORD_W - 1);

    logic [CW-1:0] since_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= LAST;
        end else if (load_strobe) begin
            since_q <= '0;
        end else begin
            since_q <= since_q + 1'b1;
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> (!tx_bit && !tx_bit_valid && !rx_bit && !rx_bit_valid));

    a_r2_strobe_period: assert property (@(posedge clk) disable iff (rst)
        load_strobe == (since_q == LAST));

    a_r3_lsb_first: assert property (@(posedge clk) disable iff (rst)
        (load_strobe && word_valid) |=> (ser_bit == ($past(word_lsb) && !$past(narrow_mode))));

    a_r4_narrow_low: assert property (@(posedge clk) disable iff (rst)
        (load_strobe && word_valid && narrow_mode) |=> (!ser_bit ##1 !ser_bit));

    a_r5_idle_zero: assert property (@(posedge clk) disable iff (rst)
        (load_strobe && !word_valid) |=> !ser_bit);

    a_r9_gap_hold: assert property (@(posedge clk) disable iff (rst)
        !rx_in_valid |=> (!rx_bit_valid && $stable(rx_bit)));

endmodule

bind sdi_serial_link sdi_serial_link_chk #(.WORD_W(WORD_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .word_lsb     (word_in[0]),
    .word_valid   (word_valid),
    .narrow_mode  (narrow_mode),
    .load_strobe  (load_strobe),
    .ser_bit      (ser_bit_w),
    .tx_bit       (tx_bit),
    .tx_bit_valid (tx_bit_valid),
    .rx_in_valid  (rx_in_valid),
    .rx_bit       (rx_bit),
    .rx_bit_valid (rx_bit_valid)
);

// File: tb/tb_sdi_serial_link.sv
module tb_sdi_serial_link;

    localparam int PERIOD = 10;
    localparam int W      = 10;

    logic clk = 1'b0;
    always #(PERIOD/2) clk = ~clk;

    logic         rst;
    logic [W-1:0] word_in;
    logic         word_valid, narrow_mode;
    logic         load_strobe, tx_bit, tx_bit_valid;
    logic         rx_in, rx_in_valid, rx_bit, rx_bit_valid;
    logic         corrupt, gap;

    assign rx_in       = tx_bit ^ corrupt;
    assign rx_in_valid = tx_bit_valid & ~gap;

    sdi_serial_link dut (
        .clk          (clk),
        .rst          (rst),
        .word_in      (word_in),
        .word_valid   (word_valid),
        .narrow_mode  (narrow_mode),
        .load_strobe  (load_strobe),
        .tx_bit       (tx_bit),
        .tx_bit_valid (tx_bit_valid),
        .rx_in        (rx_in),
        .rx_in_valid  (rx_in_valid),
        .rx_bit       (rx_bit),
        .rx_bit_valid (rx_bit_valid)
    );

    // {valid, narrow, word, expected serialized word}
    localparam logic [21:0] VEC [0:15] = '{
        {1'b1, 1'b0, 10'h3FF, 10'h3FF},
        {1'b1, 1'b0, 10'h000, 10'h000},
        {1'b1, 1'b1, 10'h3FF, 10'h3FC},
        {1'b1, 1'b0, 10'h200, 10'h200},
        {1'b0, 1'b0, 10'h155, 10'h000},
        {1'b1, 1'b1, 10'h001, 10'h000},
        {1'b1, 1'b0, 10'h2AA, 10'h2AA},
        {1'b1, 1'b1, 10'h2AB, 10'h2A8},
        {1'b1, 1'b0, 10'h040, 10'h040},
        {1'b0, 1'b1, 10'h3FF, 10'h000},
        {1'b1, 1'b0, 10'h1F3, 10'h1F3},
        {1'b1, 1'b1, 10'h10E, 10'h10C},
        {1'b1, 1'b0, 10'h00F, 10'h00F},
        {1'b1, 1'b0, 10'h3C0, 10'h3C0},
        {1'b1, 1'b1, 10'h3FE, 10'h3FC},
        {1'b1, 1'b0, 10'h123, 10'h123}
    };

    logic       expb [0:2047];
    int         push_n, tcount, run, last_idx, pend_idx, since_strobe, vec_k;
    int         checks, fails;
    bit         pend_v, pend_c, tmod, last_rx, disturbed, done;
    logic [8:0] shm;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic model_reset();
        push_n = 0; tcount = 0; run = 10; last_idx = -1;
        pend_v = 0; pend_c = 0; pend_idx = 0; tmod = 0; shm = '0;
        since_strobe = -1; last_rx = 0; disturbed = 0;
    endtask

    task automatic check_reset_outputs();
        check(tx_bit == 1'b0,       "R1", "tx_bit",       int'(tx_bit), 0);
        check(tx_bit_valid == 1'b0, "R1", "tx_bit_valid", int'(tx_bit_valid), 0);
        check(rx_bit == 1'b0,       "R1", "rx_bit",       int'(rx_bit), 0);
        check(rx_bit_valid == 1'b0, "R1", "rx_bit_valid", int'(rx_bit_valid), 0);
        check(load_strobe == 1'b1,  "R1", "load_strobe",  int'(load_strobe), 1);
    endtask

    // Called at a falling edge: check, then drive for the next rising edge.
    task automatic evaluate(input bit c, input bit g);
        logic [21:0] e;
        bit          s;
        int          cur_idx;
        bit          contiguous;
        // R2: ten cycles between strobes
        if (since_strobe >= 0) since_strobe++;
        if (load_strobe) begin
            if (since_strobe > 0) check(since_strobe == 10, "R2", "strobe spacing", since_strobe, 10);
            since_strobe = 0;
        end
        // Receive side: output of the previous edge
        if (pend_v) begin
            check(rx_bit_valid == 1'b1, "R7", "rx_bit_valid", int'(rx_bit_valid), 1);
            contiguous = (pend_idx == last_idx + 1);
            if (pend_c)          run = 0;
            else if (contiguous) run++;
            else                 run = 1;
            last_idx = pend_idx;
            if (run >= 11) begin
                if (disturbed)
                    check(rx_bit == expb[pend_idx], "R8", "recovered bit", int'(rx_bit), int'(expb[pend_idx]));
                else
                    check(rx_bit == expb[pend_idx], "R7", "descrambled bit (R3 order)", int'(rx_bit), int'(expb[pend_idx]));
            end
        end else begin
            check(rx_bit_valid == 1'b0, "R9", "rx_bit_valid in gap", int'(rx_bit_valid), 0);
            check(rx_bit == last_rx,    "R9", "rx_bit held in gap",  int'(rx_bit), int'(last_rx));
        end
        last_rx = rx_bit;
        // Transmit side: independent scrambler model
        cur_idx = -1;
        if (tx_bit_valid) begin
            s    = expb[tcount] ^ shm[3] ^ shm[8];
            shm  = {shm[7:0], s};
            tmod = tmod ^ s;
            check(tx_bit == tmod, "R6", "tx line bit", int'(tx_bit), int'(tmod));
            cur_idx = tcount;
            tcount++;
        end else if (push_n > W) begin
            check(1'b0, "R6", "tx_bit_valid dropped", 0, 1);
        end
        // Line conditions for the next edge
        corrupt = c;
        gap     = g;
        if (c || g) disturbed = 1;
        pend_v   = (cur_idx >= 0) && !g;
        pend_idx = cur_idx;
        pend_c   = c;
        // Word inputs for the next edge
        if (load_strobe) begin
            e           = VEC[vec_k % 16];
            word_valid  = e[21];
            narrow_mode = e[20];
            word_in     = e[19:10];
            for (int i = 0; i < W; i++) begin
                expb[push_n] = e[i];  // R3 LSB first, R4 / R5 via expected column
                push_n++;
            end
            vec_k++;
        end
    endtask

    task automatic run_cycles(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            evaluate((k >= 300 && k < 303) || k == 620,
                     (k >= 900 && k < 906) || k == 1200);
        end
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        checks = 0; fails = 0; vec_k = 0; done = 0;
        rst = 1'b1; corrupt = 0; gap = 0;
        word_in = '0; word_valid = 0; narrow_mode = 0;
        model_reset();
        repeat (3) @(negedge clk);
        check_reset_outputs();
        rst = 1'b0;
        model_reset();
        evaluate(0, 0);
        run_cycles(1500);

        // Reset in mid-stream with the line disturbed
        @(negedge clk);
        rst = 1'b1; corrupt = 1;
        repeat (2) @(negedge clk);
        check_reset_outputs();
        corrupt = 0;
        rst = 1'b0;
        model_reset();
        vec_k = 5;
        evaluate(0, 0);
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            evaluate(k == 150, 1'b0);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule